// File: doc/BRIEF.md
# I/O Recovery Time Enforcer

This block sits in a bus interface unit, beside the bus cycle sequencer. Before the sequencer begins a new I/O bus cycle, it asks this block for permission. The block holds that request back until a programmed minimum number of bus clocks has elapsed. The interval is counted from the address strobe of the previous I/O cycle to the address strobe of the next one, so it is a start-to-start spacing. Memory cycles are granted at once, and they never disturb the spacing.

A 3-bit code selects the spacing. Code 0 means no spacing at all. Any other code k gives 2^k bus clocks. The code register comes out of reset holding 5, which is 32 clocks. Software may rewrite the code at any time. A code that is written while a count is running leaves that count alone and takes effect at the next I/O cycle start.

The sequencer has two duties. It presents its pending cycle on `req_valid`/`req_io` and waits for `grant`. It then pulses `start_strb` (with `start_io` giving the cycle type) in the clock where the address strobe goes out.

Top module: `iort_enforcer`

## Requirements
- R1: After reset the code register holds 5. An I/O request is granted straight away. After the first I/O start, the next I/O request is granted 32 clocks after that start.
- R2: With code k from 1 to 7, the earliest following I/O start lies 2^k clocks after an I/O start. The grant to an I/O request rises exactly in that clock.
- R3: With code 0, an I/O request stays granted after an I/O start, so I/O cycles may start on consecutive clocks.
- R4: While the recovery interval is running, an I/O request gets `grant` low and `io_stall` high.
- R5: A memory request (`req_valid`=1, `req_io`=0) gets `grant` high and `io_stall` low in every clock, including while the interval runs.
- R6: A memory cycle start (`start_strb`=1, `start_io`=0) neither restarts nor lengthens a running interval.
- R7: A code written while an interval runs leaves that interval unchanged. The new code applies from the next I/O start.
- R8: When a code write and an I/O start fall in the same clock, that start uses the code held before the write. The written code applies to the following start.
- R9: With `req_valid` low, `grant` and `io_stall` are both low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Write strobe for the recovery code register |
| cfg_code | input | 3 | New recovery code, loaded when `cfg_we` is high |
| req_valid | input | 1 | The sequencer has a bus cycle waiting to start |
| req_io | input | 1 | The waiting cycle is an I/O cycle (0 means memory) |
| start_strb | input | 1 | A bus cycle starts in this clock (address strobe) |
| start_io | input | 1 | The starting cycle is an I/O cycle |
| grant | output | 1 | The waiting cycle may start |
| io_stall | output | 1 | A waiting I/O cycle is held back by the recovery interval |

## Verification
Two events can land in the same clock: a write to the code register and the I/O start that loads the counter. The bench drives both in one clock, writing a code that gives a short spacing while a long one is held. It then requires the measured gap to equal the old code's spacing, and the gap after the next start to equal the new code's spacing. A memory start in the middle of a running interval is a second collision, between memory traffic and the counter. The bench judges it by the I/O grant arriving in exactly the same clock as it would without the memory start.

// File: rtl/iort_pkg.sv
package iort_pkg;

  // Counter value loaded at an I/O start for a given code: the spacing
  // is 2^code clocks, and the start clock itself is one of them.
  function automatic int unsigned reload_of(input int unsigned code);
    if (code == 0) return 0;
    return (32'd1 << code) - 32'd1;
  endfunction

endpackage

// File: rtl/iort_rst_sync.sv
module iort_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/iort_cfg.sv
module iort_cfg #(
  parameter int CODE_W   = 3,
  parameter int RST_CODE = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  output logic [CODE_W-1:0] code
);

  logic [CODE_W-1:0] code_q, code_d;

  always_comb begin
    code_d = code_q;
    if (wr_en) code_d = wr_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     code_q <= CODE_W'(RST_CODE);
    else if (wr_en) code_q <= code_d;
  end

  assign code = code_q;

  p_cfg_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> code == $past(wr_code));

  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(code));

endmodule

// File: rtl/iort_decode.sv
module iort_decode #(
  parameter int CODE_W = 3,
  parameter int CNT_W  = 7
) (
  input  logic [CODE_W-1:0] code,
  output logic [CNT_W-1:0]  reload
);

  localparam int NCODES = 1 << CODE_W;

  logic [CNT_W-1:0] table_w [NCODES];

  for (genvar i = 0; i < NCODES; i++) begin : g_tbl
    assign table_w[i] = CNT_W'(iort_pkg::reload_of(i));
  end

  assign reload = table_w[code];

endmodule

// File: rtl/iort_counter.sv
module iort_counter #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == $past(load_val));

  p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

  p_rest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q == '0) |=> cnt_q == '0);

endmodule

// File: rtl/iort_enforcer.sv
module iort_enforcer #(
  parameter int CODE_W   = 3,
  parameter int RST_CODE = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CODE_W-1:0] cfg_code,
  input  logic              req_valid,
  input  logic              req_io,
  input  logic              start_strb,
  input  logic              start_io,
  output logic              grant,
  output logic              io_stall
);

  localparam int CNT_W = (1 << CODE_W) - 1;

  logic              rst_n_s;
  logic [CODE_W-1:0] cur_code;
  logic [CNT_W-1:0]  reload;
  logic              io_start;
  logic              busy;

  iort_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  iort_cfg #(.CODE_W(CODE_W), .RST_CODE(RST_CODE)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (cfg_we),
    .wr_code (cfg_code),
    .code    (cur_code)
  );

  iort_decode #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_dec (
    .code   (cur_code),
    .reload (reload)
  );

  assign io_start = start_strb && start_io;

  iort_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load     (io_start),
    .load_val (reload),
    .busy     (busy)
  );

  always_comb begin
    grant    = 1'b0;
    io_stall = 1'b0;
    if (req_valid) begin
      if (!req_io)   grant    = 1'b1;
      else if (busy) io_stall = 1'b1;
      else           grant    = 1'b1;
    end
  end

  p_mem_pass_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_valid && !req_io) |-> (grant && !io_stall));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    !req_valid |-> (!grant && !io_stall));

endmodule

// File: tb/iort_enforcer_bench.sv
`timescale 1ns/100ps
module iort_enforcer_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [2:0] cfg_code;
  logic       req_valid, req_io, start_strb, start_io;
  logic       grant, io_stall;

  int n_checks = 0;
  int n_bad    = 0;

  always #2.5 clk = ~clk;

  iort_enforcer u_iort_enforcer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_code(cfg_code),
    .req_valid(req_valid), .req_io(req_io), .start_strb(start_strb),
    .start_io(start_io), .grant(grant), .io_stall(io_stall)
  );

  function automatic int gap_of(input int c);
    return (c == 0) ? 1 : (1 << c);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_we = 1'b0; cfg_code = 3'd0;
    req_valid = 1'b0; req_io = 1'b0; start_strb = 1'b0; start_io = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // Called at a falling edge; leaves the bench at a falling edge.
  task automatic write_code(input logic [2:0] c);
    cfg_we = 1'b1; cfg_code = c;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Drives an I/O start now, then counts clocks until the I/O grant rises.
  // kind 1: code write at step mid; kind 2: memory start at step mid.
  task automatic run_gap(input int expv, input bit sc_we, input logic [2:0] sc_code,
                         input int mid, input int kind, input logic [2:0] mid_code,
                         input string tag);
    int  m;
    bit  stall_ok;
    bit  done;
    start_strb = 1'b1; start_io = 1'b1; req_valid = 1'b1; req_io = 1'b1;
    cfg_we = sc_we; cfg_code = sc_code;
    @(negedge clk);
    start_strb = 1'b0; cfg_we = 1'b0;
    m = 1; stall_ok = 1'b1; done = 1'b0;
    while (!done) begin
      #1;
      if (grant) done = 1'b1;
      else begin
        if (!io_stall) stall_ok = 1'b0;
        if (m == mid) begin
          if (kind == 1) begin
            cfg_we = 1'b1; cfg_code = mid_code;
          end else begin
            req_io = 1'b0;
            #0.5;
            check(grant && !io_stall, "R5", int'({grant, io_stall}), 2);
            start_strb = 1'b1; start_io = 1'b0;
          end
        end
        @(negedge clk);
        cfg_we = 1'b0; start_strb = 1'b0; start_io = 1'b1; req_io = 1'b1;
        m++;
        if (m > 400) done = 1'b1;
      end
    end
    check(m == expv, tag, m, expv);
    if (expv > 1) check(stall_ok, "R4", int'(stall_ok), 1);
  endtask

  task automatic t_reset_state();
    #1;
    check(!grant && !io_stall, "R9", int'({grant, io_stall}), 0);
    req_valid = 1'b1; req_io = 1'b1;
    #1;
    check(grant && !io_stall, "R1", int'({grant, io_stall}), 2);
  endtask

  task automatic t_default();
    run_gap(32, 1'b0, 3'd0, 0, 0, 3'd0, "R1");
  endtask

  task automatic t_table();
    for (int c = 1; c < 8; c++) begin
      write_code(3'(c));
      run_gap(gap_of(c), 1'b0, 3'd0, 0, 0, 3'd0, "R2");
    end
  endtask

  task automatic t_zero();
    write_code(3'd0);
    run_gap(1, 1'b0, 3'd0, 0, 0, 3'd0, "R3");
    run_gap(1, 1'b0, 3'd0, 0, 0, 3'd0, "R3");
  endtask

  task automatic t_idle_while_busy();
    write_code(3'd7);
    start_strb = 1'b1; start_io = 1'b1; req_valid = 1'b0;
    @(negedge clk);
    start_strb = 1'b0;
    #1;
    check(!grant && !io_stall, "R9", int'({grant, io_stall}), 0);
    req_valid = 1'b1; req_io = 1'b0;
    #1;
    check(grant && !io_stall, "R5", int'({grant, io_stall}), 2);
    repeat (130) @(negedge clk);
    req_io = 1'b1;
    #1;
    check(grant, "R2", int'(grant), 1);
  endtask

  task automatic t_mid_write();
    write_code(3'd5);
    run_gap(32, 1'b0, 3'd0, 3, 1, 3'd1, "R7");
    run_gap(2, 1'b0, 3'd0, 0, 0, 3'd0, "R7");
  endtask

  task automatic t_same_cycle();
    write_code(3'd6);
    run_gap(64, 1'b1, 3'd2, 0, 0, 3'd0, "R8");
    run_gap(4, 1'b0, 3'd0, 0, 0, 3'd0, "R8");
  endtask

  task automatic t_mem_start();
    write_code(3'd4);
    run_gap(16, 1'b0, 3'd0, 5, 2, 3'd0, "R6");
    write_code(3'd3);
    run_gap(8, 1'b0, 3'd0, 7, 2, 3'd0, "R6");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    t_reset_state();
    t_default();
    t_table();
    t_zero();
    t_idle_while_busy();
    t_mid_write();
    t_same_cycle();
    t_mem_start();
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

endmodule